// File: doc/BRIEF.md
# One-Wire Master Interrupt Status Unit

This unit sits beside the bit-timing sequencer of a one-wire bus master. It collects four event flags and presents them to the host processor through an interrupt register and a single level interrupt request. Two of the flags are bus events: a slave answering with a presence pulse while the master idles, and a bus found already pulled low just as the master is about to open a reset or a time slot. Both stay set until the host reads the interrupt register.

The other two flags form a receive double buffer. When the shift register reports a finished byte, a "shift stage full" flag rises. On the first cycle in which the receive buffer is empty, the byte moves into the buffer, so "buffer full" rises and "shift stage full" falls in that one cycle. Only a read of the receive buffer empties it. Reading the interrupt register leaves both receive flags alone. As a result, an enabled buffer-full request is raised again after every interrupt register read until the byte itself is fetched.

The interrupt line is the OR of every flag gated by its own enable bit. A read returns the flag values as they stand in the read cycle. A clear caused by that read takes effect at the following clock edge.

Top module: `owm_irq_unit`

## Requirements
- R1: After reset all four flags are 0, a read of the interrupt register (`rd_sel_i` = 0) returns 0 and `irq_o` is 0.
- R2: A cycle with `seq_idle_i` = 1 and `line_i` = 0 sets the presence flag, which reads back at bit 0 of the interrupt register from the next cycle on.
- R3: A cycle with `slot_start_i` = 1 and `line_i` = 0 sets the short flag at bit 1 of the interrupt register. A `slot_start_i` pulse while `line_i` = 1 leaves the flag at 0.
- R4: A read strobe (`rd_stb_i` = 1) with `rd_sel_i` = 0 returns the flags as they stand in that cycle. The presence and short flags become 0 at the next clock edge.
- R5: If the set condition of the presence or short flag occurs in the same cycle as an interrupt register read, the flag is 1 after that edge.
- R6: A `shift_done_i` pulse sets the shift-stage-full flag (bit 3) at the next edge. In the first cycle in which that flag is 1 and buffer-full (bit 2) is 0, the byte on `shift_data_i` is copied to the receive buffer. Bit 2 becomes 1 and bit 3 becomes 0 at the same edge.
- R7: While buffer-full is 1, shift-stage-full stays 1 whatever interrupt register reads occur, and no transfer takes place.
- R8: A read strobe with `rd_sel_i` = 1 returns the buffered byte and clears buffer-full at the next edge. Interrupt register reads do not change buffer-full.
- R9: `irq_o` is 1 exactly when some flag and its bit in `irq_en_i` are both 1. Bit positions are the same as in the interrupt register. With buffer-full and its enable set, `irq_o` stays 1 after an interrupt register read.
- R10: Interrupt register bits above bit 3 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Sampled bus line level |
| seq_idle_i | input | 1 | Sequencer is idle |
| slot_start_i | input | 1 | Strobe: a reset or time slot is about to begin |
| shift_done_i | input | 1 | Strobe: the shift register holds a complete byte |
| shift_data_i | input | DATA_W (8) | Parallel content of the receive shift register |
| rd_stb_i | input | 1 | Host register read strobe |
| rd_sel_i | input | 1 | Read target: 0 interrupt register, 1 receive buffer |
| irq_en_i | input | 4 | Per-flag interrupt enables, bit order as in the interrupt register |
| rd_data_o | output | DATA_W (8) | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is an overrun. In that state a second byte completes while the first still sits unread in the buffer, so both receive flags are 1 and interrupt register reads must leave both untouched. The stimulus gets there by sending two `shift_done_i` pulses without any buffer read in between. It then reads the interrupt register more than once, and after that drains the buffer. This lets the bench see the delayed transfer of the waiting byte one cycle after the buffer read. The set-versus-clear collision is reached by asserting the presence condition in the very cycle of an interrupt register read.

// File: rtl/owm_irq_pkg.sv
package owm_irq_pkg;
  localparam int FLAG_W    = 4;
  localparam int FLAG_PRES = 0;
  localparam int FLAG_SHRT = 1;
  localparam int FLAG_RBF  = 2;
  localparam int FLAG_SRF  = 3;
  localparam int EVT_N     = 2;

  typedef enum logic {
    SEL_IRQ_REG = 1'b0,
    SEL_RX_BUF  = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/owm_rst_sync.sv
module owm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/owm_sticky_flag.sv
module owm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/owm_rx_buffer.sv
module owm_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_done_i,
  input  logic [DATA_W-1:0] shift_data_i,
  input  logic              buf_rd_i,
  output logic              srf_o,
  output logic              rbf_o,
  output logic [DATA_W-1:0] buf_data_o
);
  logic              srf_q, srf_d;
  logic              rbf_q, rbf_d;
  logic [DATA_W-1:0] data_q;
  logic              xfer;

  always_comb begin
    xfer  = srf_q & ~rbf_q;
    srf_d = shift_done_i | (srf_q & ~xfer);
    rbf_d = xfer | (rbf_q & ~buf_rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srf_q <= 1'b0;
      rbf_q <= 1'b0;
    end else begin
      srf_q <= srf_d;
      rbf_q <= rbf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (xfer) data_q <= shift_data_i;
  end

  assign srf_o      = srf_q;
  assign rbf_o      = rbf_q;
  assign buf_data_o = data_q;

  assert_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (srf_o && !rbf_o && !shift_done_i) |=> (rbf_o && !srf_o));
  assert_srf_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srf_o && rbf_o) |=> srf_o);
  assert_rbf_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rbf_o && !buf_rd_i) |=> (rbf_o && $stable(buf_data_o)));
  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done_i |=> srf_o);
endmodule

// File: rtl/owm_irq_merge.sv
module owm_irq_merge
  import owm_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] en_i,
  input  logic              rd_sel_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [FLAG_W-1:0] masked;
  logic [DATA_W-1:0] irq_reg;
  rd_sel_e           sel;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_mask
    assign masked[g] = flags_i[g] & en_i[g];
  end

  always_comb begin
    irq_reg              = '0;
    irq_reg[FLAG_W-1:0]  = flags_i;
    sel                  = rd_sel_e'(rd_sel_i);
    irq_o                = |masked;
    rd_data_o            = (sel == SEL_RX_BUF) ? buf_data_i : irq_reg;
  end
endmodule

// File: rtl/owm_irq_unit.sv
module owm_irq_unit
  import owm_irq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              seq_idle_i,
  input  logic              slot_start_i,
  input  logic              shift_done_i,
  input  logic [DATA_W-1:0] shift_data_i,
  input  logic              rd_stb_i,
  input  logic              rd_sel_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic              rst_int_n;
  logic [EVT_N-1:0]  evt_set;
  logic [EVT_N-1:0]  evt_flag;
  logic              reg_rd;
  logic              buf_rd;
  logic              srf, rbf;
  logic [DATA_W-1:0] buf_data;
  logic [FLAG_W-1:0] flags;

  owm_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  always_comb begin
    reg_rd             = rd_stb_i & (rd_sel_e'(rd_sel_i) == SEL_IRQ_REG);
    buf_rd             = rd_stb_i & (rd_sel_e'(rd_sel_i) == SEL_RX_BUF);
    evt_set[FLAG_PRES] = seq_idle_i & ~line_i;
    evt_set[FLAG_SHRT] = slot_start_i & ~line_i;
  end

  for (genvar e = 0; e < EVT_N; e++) begin : g_evt
    owm_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_int_n),
      .set_i(evt_set[e]), .clr_i(reg_rd), .flag_o(evt_flag[e])
    );
  end

  owm_rx_buffer #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .shift_done_i(shift_done_i), .shift_data_i(shift_data_i),
    .buf_rd_i(buf_rd), .srf_o(srf), .rbf_o(rbf), .buf_data_o(buf_data)
  );

  always_comb begin
    flags            = '0;
    flags[FLAG_PRES] = evt_flag[FLAG_PRES];
    flags[FLAG_SHRT] = evt_flag[FLAG_SHRT];
    flags[FLAG_RBF]  = rbf;
    flags[FLAG_SRF]  = srf;
  end

  owm_irq_merge #(.DATA_W(DATA_W)) u_merge (
    .flags_i(flags), .en_i(irq_en_i), .rd_sel_i(rd_sel_i),
    .buf_data_i(buf_data), .irq_o(irq_o), .rd_data_o(rd_data_o)
  );

  assert_presence_set_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seq_idle_i && !line_i) |=> flags[FLAG_PRES]);
  assert_short_set_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_start_i && !line_i) |=> flags[FLAG_SHRT]);
  assert_rbf_reassert_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rbf && irq_en_i[FLAG_RBF]) |-> irq_o);
  assert_no_req_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_en_i == '0) |-> !irq_o);
endmodule

// File: tb/owm_irq_unit_bench.sv
module owm_irq_unit_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_i = 1'b1;
  logic          seq_idle_i = 1'b0;
  logic          slot_start_i = 1'b0;
  logic          shift_done_i = 1'b0;
  logic [DW-1:0] shift_data_i = '0;
  logic          rd_stb_i = 1'b0;
  logic          rd_sel_i = 1'b0;
  logic [3:0]    irq_en_i = 4'h0;
  logic [DW-1:0] rd_data_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  owm_irq_unit u_owm_irq_unit (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .seq_idle_i(seq_idle_i),
    .slot_start_i(slot_start_i), .shift_done_i(shift_done_i),
    .shift_data_i(shift_data_i), .rd_stb_i(rd_stb_i), .rd_sel_i(rd_sel_i),
    .irq_en_i(irq_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #3;
    if (rd_stb_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %02h expected none", rd_data_o);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data_o !== e) begin
          errors++;
          $display("FAIL %s: read data actual %02h expected %02h", t, rd_data_o, e);
        end
      end
    end
  end

  task automatic idle_cycle();
    @(negedge clk); #1;
    seq_idle_i = 0; slot_start_i = 0; shift_done_i = 0; rd_stb_i = 0;
  endtask

  task automatic do_read(input logic sel, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); #1;
    seq_idle_i = 0; slot_start_i = 0; shift_done_i = 0;
    rd_stb_i = 1; rd_sel_i = sel;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    seq_idle_i = 0; slot_start_i = 0; shift_done_i = 0; rd_stb_i = 0;
    #2;
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", tag, irq_o, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) idle_cycle();

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    do_read(0, 8'h00, "R1 reset flags");

    // R2 presence
    irq_en_i = 4'h1;
    @(negedge clk); #1; rd_stb_i = 0; seq_idle_i = 1; line_i = 0;
    @(negedge clk); #1; seq_idle_i = 0; line_i = 1;
    #2; checks++;
    if (irq_o !== 1'b1) begin errors++; $display("FAIL R9 presence irq: actual %0b expected 1", irq_o); end
    do_read(0, 8'h01, "R2 presence bit0");
    do_read(0, 8'h00, "R4 presence cleared");

    // R3 short, and no set with line high
    @(negedge clk); #1; rd_stb_i = 0; slot_start_i = 1; line_i = 0;
    @(negedge clk); #1; slot_start_i = 0; line_i = 1;
    do_read(0, 8'h02, "R3 short bit1");
    @(negedge clk); #1; rd_stb_i = 0; slot_start_i = 1; line_i = 1;
    do_read(0, 8'h00, "R3 no short with line high");

    // R5 set wins over clear-on-read
    @(negedge clk); #1; rd_stb_i = 0;
    @(negedge clk); #1;
    rd_stb_i = 1; rd_sel_i = 0; seq_idle_i = 1; line_i = 0;
    exp_q.push_back(8'h00); tag_q.push_back("R5 pre-clear value");
    @(negedge clk); #1; seq_idle_i = 0; line_i = 1; rd_stb_i = 0;
    do_read(0, 8'h01, "R5 set survives read");
    do_read(0, 8'h00, "R4 cleared after read");

    // R6 single byte transfer, R8 buffer read
    irq_en_i = 4'h0;
    @(negedge clk); #1; rd_stb_i = 0; shift_data_i = 8'hA5; shift_done_i = 1;
    do_read(0, 8'h08, "R6 shift stage full");
    do_read(0, 8'h04, "R6 moved to buffer");
    check_irq(1'b0, "R9 no enables");
    do_read(1, 8'hA5, "R8 buffer byte");
    do_read(0, 8'h00, "R8 buffer cleared");

    // R7 overrun with both flags, R9 re-assertion
    irq_en_i = 4'h4;
    @(negedge clk); #1; rd_stb_i = 0; shift_data_i = 8'h5A; shift_done_i = 1;
    idle_cycle();
    @(negedge clk); #1; shift_data_i = 8'h3C; shift_done_i = 1;
    do_read(0, 8'h0C, "R7 both receive flags");
    do_read(0, 8'h0C, "R7 read leaves srf and rbf");
    check_irq(1'b1, "R9 re-asserted after reg read");
    irq_en_i = 4'h2;
    check_irq(1'b0, "R9 other enable only");
    // R10 all flags set, upper bits zero
    @(negedge clk); #1; seq_idle_i = 1; slot_start_i = 1; line_i = 0;
    @(negedge clk); #1; seq_idle_i = 0; slot_start_i = 0; line_i = 1;
    do_read(0, 8'h0F, "R10 all flags upper zero");
    do_read(1, 8'h5A, "R8 first byte");
    do_read(0, 8'h08, "R6 waiting byte before transfer");
    do_read(1, 8'h3C, "R6 second byte");
    do_read(0, 8'h00, "R8 all drained");
    idle_cycle();
    idle_cycle();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule